// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

This block sits on two independent byte-wide MPEG transport streams and forwards or discards each 188-byte packet according to its packet identifier (PID). Every stream owns a drop table of one bit per PID, 8192 bits held as 1024 bytes. When the third byte of a packet arrives, the block forms the 13-bit PID from the header, looks up the matching table bit and decides for the whole packet. A table bit of 1 discards the packet and a bit of 0 lets it through. PIDs below 0x20 bypass the table and are always forwarded. A packet whose first byte is not the 0x47 sync value is discarded.

Each stream passes through a three-stage delay line. Header bytes 0 and 1 are still inside the block when the decision is made, so no byte of a discarded packet ever reaches the output. Software reaches both tables through three indirect registers: an index-low register, an index-high register that also selects the stream, and a data register. Software changes one PID by reading the data register, editing one bit and writing the byte back.

Each stream has a controller with four states. GS_IDLE waits for a start of packet. GS_HDR1 takes header byte 1. GS_HDR2 takes header byte 2, and the forward/drop decision is made in this state. GS_BODY counts the remaining bytes. The transitions are as follows:
- An accepted start of packet moves any state to GS_HDR1.
- A plain byte moves GS_HDR1 to GS_HDR2.
- A plain byte moves GS_HDR2 to GS_BODY.
- The 188th byte moves GS_BODY back to GS_IDLE.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, no output is valid, both index registers read 0x00, and every table byte of both streams reads 0x00, so every PID passes.
- R2: A byte of a forwarded packet that is accepted in cycle c appears on the output in cycle c+3 with the same value. The output start-of-packet flag is set only on the packet's first byte.
- R3: The PID is {byte1[4:0], byte2}. It is controlled by bit (PID & 7) of table byte (PID >> 3). A 1 suppresses all 188 bytes of the packet and a 0 forwards all 188 bytes.
- R4: PIDs 0x0000 to 0x001F are forwarded even when their table bits are 1. PID 0x0020 obeys the table.
- R5: A packet whose first byte is not 0x47 is suppressed whole, even when its table bit is 0.
- R6: Register select code 0 is index bits 7:0 and code 1 is the high register: bits 1:0 are index bits 9:8 and bit 2 selects the stream (0 or 1). Code 2 is the table data byte at that index. Every register reads back what was written, and a data write changes only the addressed byte.
- R7: The two streams have separate tables. A table bit set for one stream has no effect on the other stream.
- R8: A valid byte that arrives while no packet is open, without start of packet, never reaches the output.
- R9: A start of packet that arrives before a packet's PID is complete discards the truncated header bytes and begins a new packet. The new packet is then judged normally.
- R10: When a data write to a table byte falls in the same cycle as a lookup of that byte, the packet being judged sees the old value. Later packets see the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_STREAMS | Input byte valid, one bit per stream |
| in_sop | input | NUM_STREAMS | First byte of a packet, one bit per stream |
| in_data | input | 8*NUM_STREAMS | Input bytes, stream s in bits 8s+7:8s |
| out_valid | output | NUM_STREAMS | Output byte valid per stream |
| out_sop | output | NUM_STREAMS | Output first byte of a forwarded packet |
| out_data | output | 8*NUM_STREAMS | Output bytes, zero when not valid |
| host_wr | input | 1 | Register write strobe |
| host_reg | input | 2 | Register select: 0 index low, 1 index high/stream, 2 data |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Read data of the selected register |

## Verification
Two functions can fall in the same cycle: the lookup of a table byte while header byte 2 is accepted, and a host write to that same byte. The bench places the index on the byte for the packet's PID in advance. It then raises the data write, which sets that PID's bit, in the exact cycle it presents header byte 2. The bench judges the outcome from the output byte count: the packet in flight must be forwarded complete, a read of the data register must show the new byte, and a second packet with the same PID must produce no output at all.

// File: rtl/ts_filt_pkg.sv
package ts_filt_pkg;

    parameter int          PKT_BYTES    = 188;
    parameter int          PID_BITS     = 13;
    parameter int          BYPASS_PIDS  = 32;
    parameter logic [7:0]  SYNC_VALUE   = 8'h47;
    parameter int          STREAMS      = 2;

    // header byte index at which the PID becomes complete
    parameter int          PID_LAST_IDX = 2;

    // host register select codes
    localparam logic [1:0] REG_IDX_LO = 2'd0;
    localparam logic [1:0] REG_IDX_HI = 2'd1;
    localparam logic [1:0] REG_DATA   = 2'd2;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_HDR1,
        GS_HDR2,
        GS_BODY
    } gate_state_e;

    typedef struct packed {
        logic       own;   // byte belongs to a tracked packet
        logic       sop;
        logic [7:0] dat;
    } stage_t;

endpackage

// File: rtl/ts_pid_bitmap.sv
module ts_pid_bitmap #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] hrd_idx,
    output logic [7:0]       hrd_byte,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [7:0]       lk_byte
);

    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= 8'h00;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_byte;
        end
    end

    // both read ports see the value held before any write in this cycle
    always_comb begin
        hrd_byte = mem_q[hrd_idx];
        lk_byte  = mem_q[lk_idx];
    end

endmodule

// File: rtl/ts_host_port.sv
module ts_host_port
    import ts_filt_pkg::*;
#(
    parameter int NUM_STREAMS = 2,
    parameter int IDX_W       = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [1:0]               host_reg,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    input  logic [NUM_STREAMS*8-1:0] rd_bytes,
    output logic [IDX_W-1:0]         ptr_idx,
    output logic [7:0]               ptr_byte,
    output logic [NUM_STREAMS-1:0]   tbl_we
);

    localparam int SEL_W  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;
    localparam int HIGH_W = IDX_W - 8;

    logic [7:0]       lo_q;
    logic [7:0]       hi_q;
    logic [SEL_W-1:0] strm_w;
    logic             data_wr_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= 8'h00;
            hi_q <= 8'h00;
        end else if (host_wr) begin
            if (host_reg == REG_IDX_LO) lo_q <= host_wdata;
            if (host_reg == REG_IDX_HI) hi_q <= host_wdata;
        end
    end

    assign ptr_idx   = {hi_q[HIGH_W-1:0], lo_q};
    assign strm_w    = hi_q[HIGH_W +: SEL_W];
    assign ptr_byte  = host_wdata;
    assign data_wr_w = host_wr && (host_reg == REG_DATA);

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_we
        assign tbl_we[s] = data_wr_w && (strm_w == SEL_W'(s));
    end

    always_comb begin
        unique case (host_reg)
            REG_IDX_LO: host_rdata = lo_q;
            REG_IDX_HI: host_rdata = hi_q;
            REG_DATA:   host_rdata = rd_bytes[strm_w*8 +: 8];
            default:    host_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/ts_pkt_gate.sv
module ts_pkt_gate
    import ts_filt_pkg::*;
#(
    parameter int         PKT_LEN  = 188,
    parameter int         PID_W    = 13,
    parameter int         BYPASS_N = 32,
    parameter logic [7:0] SYNC_B   = 8'h47
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic [7:0]         in_data,
    output logic [PID_W-4:0]   lk_idx,
    input  logic [7:0]         lk_byte,
    output logic               out_valid,
    output logic               out_sop,
    output logic [7:0]         out_data
);

    localparam int HI_W  = PID_W - 8;
    localparam int CNT_W = $clog2(PKT_LEN);
    localparam int DEPTH = PID_LAST_IDX + 1;

    gate_state_e      cur_st, nxt_st;
    logic [CNT_W-1:0] idx_q;
    logic [HI_W-1:0]  pid_hi_q;
    logic             sync_ok_q;
    logic             pass_q;
    stage_t           pipe_q [DEPTH];

    logic             start_w;
    logic             beat_w;
    logic [PID_W-1:0] pid_w;
    logic             pass_w;
    logic             in_hdr_w;

    assign start_w  = in_valid & in_sop;
    assign beat_w   = in_valid & ~in_sop;
    assign pid_w    = {pid_hi_q, in_data};
    assign lk_idx   = pid_w[PID_W-1:3];
    assign pass_w   = sync_ok_q &
                      ((pid_w < PID_W'(BYPASS_N)) | ~lk_byte[pid_w[2:0]]);
    assign in_hdr_w = (cur_st == GS_HDR1) || (cur_st == GS_HDR2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= GS_IDLE;
        else        cur_st <= nxt_st;
    end

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            GS_IDLE: begin
                if (start_w) nxt_st = GS_HDR1;
            end
            GS_HDR1: begin
                if (start_w)     nxt_st = GS_HDR1;
                else if (beat_w) nxt_st = GS_HDR2;
            end
            GS_HDR2: begin
                if (start_w)     nxt_st = GS_HDR1;
                else if (beat_w) nxt_st = GS_BODY;
            end
            GS_BODY: begin
                if (start_w)
                    nxt_st = GS_HDR1;
                else if (beat_w && idx_q == CNT_W'(PKT_LEN - 1))
                    nxt_st = GS_IDLE;
            end
            default: nxt_st = GS_IDLE;
        endcase
    end

    // header capture, decision and delay line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            pid_hi_q  <= '0;
            sync_ok_q <= 1'b0;
            pass_q    <= 1'b0;
            for (int k = 0; k < DEPTH; k++) begin
                pipe_q[k] <= '0;
            end
        end else begin
            if (start_w) begin
                idx_q     <= CNT_W'(1);
                sync_ok_q <= (in_data == SYNC_B);
                if (in_hdr_w) pass_q <= 1'b0;
            end else if (beat_w && cur_st != GS_IDLE) begin
                idx_q <= idx_q + 1'b1;
                if (cur_st == GS_HDR1) pid_hi_q <= in_data[HI_W-1:0];
                if (cur_st == GS_HDR2) pass_q   <= pass_w;
            end
            pipe_q[0].own <= in_valid & (in_sop | (cur_st != GS_IDLE));
            pipe_q[0].sop <= start_w;
            pipe_q[0].dat <= in_data;
            for (int k = 1; k < DEPTH; k++) begin
                pipe_q[k] <= pipe_q[k-1];
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = pipe_q[DEPTH-1].own & pass_q;
        out_sop   = out_valid & pipe_q[DEPTH-1].sop;
        out_data  = out_valid ? pipe_q[DEPTH-1].dat : 8'h00;
    end

endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
    import ts_filt_pkg::*;
#(
    parameter int         NUM_STREAMS = STREAMS,
    parameter int         PKT_LEN     = PKT_BYTES,
    parameter int         PID_W       = PID_BITS,
    parameter int         BYPASS_N    = BYPASS_PIDS,
    parameter logic [7:0] SYNC_B      = SYNC_VALUE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_STREAMS-1:0]   in_valid,
    input  logic [NUM_STREAMS-1:0]   in_sop,
    input  logic [NUM_STREAMS*8-1:0] in_data,
    output logic [NUM_STREAMS-1:0]   out_valid,
    output logic [NUM_STREAMS-1:0]   out_sop,
    output logic [NUM_STREAMS*8-1:0] out_data,
    input  logic                     host_wr,
    input  logic [1:0]               host_reg,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata
);

    localparam int IDX_W = PID_W - 3;

    logic [IDX_W-1:0]         ptr_idx;
    logic [7:0]               ptr_byte;
    logic [NUM_STREAMS-1:0]   tbl_we;
    logic [NUM_STREAMS*8-1:0] hrd_flat;

    ts_host_port #(
        .NUM_STREAMS (NUM_STREAMS),
        .IDX_W       (IDX_W)
    ) i_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_reg   (host_reg),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rd_bytes   (hrd_flat),
        .ptr_idx    (ptr_idx),
        .ptr_byte   (ptr_byte),
        .tbl_we     (tbl_we)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
        logic [IDX_W-1:0] lk_idx;
        logic [7:0]       lk_byte;

        ts_pid_bitmap #(
            .IDX_W (IDX_W)
        ) i_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (tbl_we[s]),
            .wr_idx   (ptr_idx),
            .wr_byte  (ptr_byte),
            .hrd_idx  (ptr_idx),
            .hrd_byte (hrd_flat[s*8 +: 8]),
            .lk_idx   (lk_idx),
            .lk_byte  (lk_byte)
        );

        ts_pkt_gate #(
            .PKT_LEN  (PKT_LEN),
            .PID_W    (PID_W),
            .BYPASS_N (BYPASS_N),
            .SYNC_B   (SYNC_B)
        ) i_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[s]),
            .in_sop    (in_sop[s]),
            .in_data   (in_data[s*8 +: 8]),
            .lk_idx    (lk_idx),
            .lk_byte   (lk_byte),
            .out_valid (out_valid[s]),
            .out_sop   (out_sop[s]),
            .out_data  (out_data[s*8 +: 8])
        );
    end

endmodule

// File: rtl/ts_pid_filter_chk.sv
module ts_pid_filter_chk #(
    parameter int         NUM_STREAMS = 2,
    parameter logic [7:0] SYNC_B      = 8'h47
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_STREAMS-1:0]   in_valid,
    input logic [NUM_STREAMS*8-1:0] in_data,
    input logic [NUM_STREAMS-1:0]   out_valid,
    input logic [NUM_STREAMS-1:0]   out_sop,
    input logic [NUM_STREAMS*8-1:0] out_data,
    input logic                     host_wr,
    input logic [1:0]               host_reg,
    input logic [7:0]               host_rdata
);

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_chk
        // R2: every output byte entered three cycles earlier
        a_r2_latency_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[s] |-> $past(in_valid[s], 3));

        // R2: output byte equals the input byte three cycles earlier
        a_r2_latency_data: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[s] |-> (out_data[s*8 +: 8] == $past(in_data[s*8 +: 8], 3)));

        // R5: a forwarded packet always starts with the sync value
        a_r5_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
            out_sop[s] |-> (out_data[s*8 +: 8] == SYNC_B));

        // R3: forwarded output begins only at a packet start
        a_r3_whole_packet: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_valid[s]) |-> out_sop[s]);
    end

    // R6: register read data only changes after a write or a new select
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(host_wr) && $stable(host_reg)) |-> $stable(host_rdata));

endmodule

bind ts_pid_filter ts_pid_filter_chk #(
    .NUM_STREAMS (NUM_STREAMS),
    .SYNC_B      (SYNC_B)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_data   (out_data),
    .host_wr    (host_wr),
    .host_reg   (host_reg),
    .host_rdata (host_rdata)
);

// File: tb/test_ts_pid_filter.sv
module test_ts_pid_filter;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 2;
    localparam int PLEN       = 188;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] in_valid = '0;
    logic [NS-1:0] in_sop = '0;
    logic [NS*8-1:0] in_data = '0;
    logic [NS-1:0] out_valid;
    logic [NS-1:0] out_sop;
    logic [NS*8-1:0] out_data;
    logic          host_wr = 1'b0;
    logic [1:0]    host_reg = 2'd0;
    logic [7:0]    host_wdata = 8'h00;
    logic [7:0]    host_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int ob [NS];
    int os [NS];
    int osum [NS];

    logic       lat0_v, lat0_s, lat1_v, lat1_s;
    logic [7:0] lat0_d, lat1_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_pid_filter i_ts_pid_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_data   (out_data),
        .host_wr    (host_wr),
        .host_reg   (host_reg),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    initial begin
        for (int s = 0; s < NS; s++) begin
            ob[s] = 0; os[s] = 0; osum[s] = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < NS; s++) begin
                if (out_valid[s]) begin
                    ob[s]   = ob[s] + 1;
                    osum[s] = osum[s] + int'(out_data[s*8 +: 8]);
                    if (out_sop[s]) os[s] = os[s] + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pkt_byte(input logic [7:0] sync, input int pid,
                                           input int seed, input int k);
        if (k == 0) return sync;
        if (k == 1) return 8'((pid >> 8) & 32'h1F);
        if (k == 2) return 8'(pid & 32'hFF);
        return 8'((seed + k * 7) & 32'hFF);
    endfunction

    function automatic int pkt_sum(input logic [7:0] sync, input int pid, input int seed);
        int acc = 0;
        for (int k = 0; k < PLEN; k++) acc += int'(pkt_byte(sync, pid, seed, k));
        return acc;
    endfunction

    task automatic host_write(input logic [1:0] r, input logic [7:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_reg = r; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] r, output logic [7:0] v);
        @(negedge clk);
        host_wr = 1'b0; host_reg = r;
        #1;
        v = host_rdata;
    endtask

    task automatic point(input int s, input int pid);
        host_write(2'd0, 8'((pid >> 3) & 32'hFF));
        host_write(2'd1, 8'(((pid >> 11) & 32'h3) | (s << 2)));
    endtask

    task automatic set_bit(input int s, input int pid, input logic v);
        logic [7:0] b;
        point(s, pid);
        host_read(2'd2, b);
        b[pid & 7] = v;
        host_write(2'd2, b);
    endtask

    task automatic send_pkt(input int s, input logic [7:0] sync, input int pid,
                            input int seed, input bit wr_at2, input logic [7:0] wv);
        for (int k = 0; k < PLEN; k++) begin
            @(negedge clk);
            in_valid[s] = 1'b1;
            in_sop[s]   = (k == 0);
            in_data[s*8 +: 8] = pkt_byte(sync, pid, seed, k);
            if (wr_at2 && k == 2) begin
                host_wr = 1'b1; host_reg = 2'd2; host_wdata = wv;
            end
            if (k == 3) begin
                host_wr = 1'b0;
                lat0_v = out_valid[s]; lat0_s = out_sop[s]; lat0_d = out_data[s*8 +: 8];
            end
            if (k == 4) begin
                lat1_v = out_valid[s]; lat1_s = out_sop[s]; lat1_d = out_data[s*8 +: 8];
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = '0; in_sop = '0; in_data = '0;
        repeat (n - 1) @(negedge clk);
    endtask

    // send one packet and judge whether it was forwarded whole or not at all
    task automatic run_pkt(input int s, input logic [7:0] sync, input int pid,
                           input int seed, input bit fwd, input string req);
        int b0, s0, m0;
        b0 = ob[s]; s0 = os[s]; m0 = osum[s];
        send_pkt(s, sync, pid, seed, 1'b0, 8'h00);
        idle(6);
        check(ob[s] - b0 == (fwd ? PLEN : 0), req, ob[s] - b0, fwd ? PLEN : 0);
        if (fwd) begin
            check(os[s] - s0 == 1, req, os[s] - s0, 1);
            check(osum[s] - m0 == pkt_sum(sync, pid, seed), req,
                  osum[s] - m0, pkt_sum(sync, pid, seed));
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
        host_read(2'd0, v); check(v == 8'h00, "R1 idx_lo", v, 0);
        host_read(2'd1, v); check(v == 8'h00, "R1 idx_hi", v, 0);
        host_read(2'd2, v); check(v == 8'h00, "R1 byte0 s0", v, 0);
        host_write(2'd0, 8'hFF); host_write(2'd1, 8'h07);
        host_read(2'd2, v); check(v == 8'h00, "R1 byte3ff s1", v, 0);
    endtask

    task automatic t_latency();
        send_pkt(0, 8'h47, 32'h100, 1, 1'b0, 8'h00);
        idle(6);
        check(lat0_v && lat0_s && lat0_d == 8'h47, "R2 byte0 at c+3",
              {lat0_v, lat0_s, lat0_d}, {2'b11, 8'h47});
        check(lat1_v && !lat1_s && lat1_d == 8'h01, "R2 byte1 at c+3",
              {lat1_v, lat1_s, lat1_d}, {2'b10, 8'h01});
        run_pkt(0, 8'h47, 32'h100, 9, 1'b1, "R3 clear bit forwards");
    endtask

    task automatic t_drop();
        logic [7:0] v;
        set_bit(0, 32'h1234, 1'b1);
        host_read(2'd2, v); check(v == 8'h10, "R6 rmw byte", v, 8'h10);
        run_pkt(0, 8'h47, 32'h1234, 3, 1'b0, "R3 set bit drops");
        run_pkt(0, 8'h47, 32'h1235, 4, 1'b1, "R3 neighbour bit passes");
    endtask

    task automatic t_bypass();
        for (int b = 0; b < 5; b++) begin
            host_write(2'd0, 8'(b)); host_write(2'd1, 8'h00); host_write(2'd2, 8'hFF);
        end
        run_pkt(0, 8'h47, 32'h0000, 5, 1'b1, "R4 pid 0x0 bypass");
        run_pkt(0, 8'h47, 32'h001F, 6, 1'b1, "R4 pid 0x1f bypass");
        run_pkt(0, 8'h47, 32'h0020, 7, 1'b0, "R4 pid 0x20 uses table");
    endtask

    task automatic t_sync();
        run_pkt(0, 8'h46, 32'h100, 8, 1'b0, "R5 bad sync drops");
        run_pkt(0, 8'h47, 32'h100, 8, 1'b1, "R5 good sync passes");
    endtask

    task automatic t_regs();
        logic [7:0] v;
        host_write(2'd0, 8'hA5); host_write(2'd1, 8'h07);
        host_read(2'd0, v); check(v == 8'hA5, "R6 idx_lo readback", v, 8'hA5);
        host_read(2'd1, v); check(v == 8'h07, "R6 idx_hi readback", v, 8'h07);
        host_write(2'd2, 8'h3C);
        host_read(2'd2, v); check(v == 8'h3C, "R6 data readback", v, 8'h3C);
        host_write(2'd1, 8'h03);
        host_read(2'd2, v); check(v == 8'h00, "R7 other stream byte", v, 0);
        host_write(2'd0, 8'hA4); host_write(2'd1, 8'h07);
        host_read(2'd2, v); check(v == 8'h00, "R6 adjacent byte", v, 0);
    endtask

    task automatic t_streams();
        set_bit(1, 32'h0ABC, 1'b1);
        run_pkt(0, 8'h47, 32'h0ABC, 10, 1'b1, "R7 stream0 unaffected");
        run_pkt(1, 8'h47, 32'h0ABC, 11, 1'b0, "R7 stream1 drops");
        run_pkt(1, 8'h47, 32'h0ABD, 12, 1'b1, "R7 stream1 passes");
    endtask

    task automatic t_stray();
        int b0;
        b0 = ob[0];
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            in_valid[0] = 1'b1; in_sop[0] = 1'b0; in_data[7:0] = 8'(8'h47 + k);
        end
        idle(6);
        check(ob[0] == b0, "R8 stray bytes", ob[0] - b0, 0);
    endtask

    task automatic t_restart();
        int b0, s0, m0;
        run_pkt(0, 8'h47, 32'h100, 13, 1'b1, "R9 prior packet");
        b0 = ob[0]; s0 = os[0]; m0 = osum[0];
        @(negedge clk);
        in_valid[0] = 1'b1; in_sop[0] = 1'b1; in_data[7:0] = 8'h47;
        @(negedge clk);
        in_sop[0] = 1'b0; in_data[7:0] = 8'h01;
        send_pkt(0, 8'h47, 32'h101, 14, 1'b0, 8'h00);
        idle(6);
        check(ob[0] - b0 == PLEN, "R9 byte count", ob[0] - b0, PLEN);
        check(os[0] - s0 == 1, "R9 sop count", os[0] - s0, 1);
        check(osum[0] - m0 == pkt_sum(8'h47, 32'h101, 14), "R9 content",
              osum[0] - m0, pkt_sum(8'h47, 32'h101, 14));
    endtask

    task automatic t_collision();
        int b0;
        logic [7:0] v;
        point(0, 32'h0777);
        b0 = ob[0];
        send_pkt(0, 8'h47, 32'h0777, 15, 1'b1, 8'h80);
        idle(6);
        check(ob[0] - b0 == PLEN, "R10 old value wins", ob[0] - b0, PLEN);
        host_read(2'd2, v); check(v == 8'h80, "R10 write landed", v, 8'h80);
        run_pkt(0, 8'h47, 32'h0777, 16, 1'b0, "R10 next packet drops");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_latency();
        t_drop();
        t_bypass();
        t_sync();
        t_regs();
        t_streams();
        t_stray();
        t_restart();
        t_collision();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule